// File: doc/BRIEF.md
# Two-Format Hit Event Readout Formatter

The formatter takes one accepted event at a time from a derandomizing buffer and turns it into a byte stream on an 8-bit bus. The stream carries one byte per clock. An event holds one to three bunch crossings of 32 channels. Each channel slot has a hit flag and a 6-bit fine-time code. Before formatting, the configured channel suppression mask clears the hits of any channel whose mask bit is set. The stream always opens with four header bytes that carry the chip identifier, the bunch counter, the event counter and a status byte.

The format is chosen per event. In the full format every channel sends one byte, and a channel that was hit in any of the captured crossings reports the time of its earliest hit. In the sparse format each crossing sends its 32-bit hit pattern, followed by time bytes for the hit channels only. Every event is limited to a fixed byte budget, 36 bytes by default, which is the number of 40 MHz cycles in the readout window. An event that would exceed the budget is cut off, and the status byte reports the cut.

Top module: `rd_formatter`

## Requirements
- R1: After reset, dataValid is 0, dataOut is 0x00 and evReady is 0 while evValid is 0.
- R2: evReady is high only in a cycle where evValid is high and the block is idle, and the event is taken at that clock edge. The first header byte is valid two clock edges after the capture edge.
- R3: The header is four bytes, in this order: {chipId[3:0], bunch[11:8]}, bunch[7:0], event id, and the status byte {truncated, overflow, sparse, 5'b00000}.
- R4: In full format, 32 bytes follow the header in ascending channel order. A hit channel sends {1'b1, 1'b0, time[5:0]}. A channel with no hit sends 0x3F.
- R5: In full format, a channel hit in several crossings reports the time from the lowest-numbered crossing that has a hit.
- R6: A channel whose cfgChanMask bit is 1 is treated as not hit in both formats.
- R7: In sparse format, each crossing from 0 upward sends four mask bytes, most significant byte first (bits 31:24 first), and then one byte {1'b1, 1'b0, time} for each hit channel in ascending channel order.
- R8: Crossings with index at or above evCount are ignored entirely.
- R9: An event never carries more than BUDGET bytes including its header. The truncated status bit is 1 exactly when the complete format would need more than BUDGET bytes, and then the first BUDGET bytes are sent.
- R10: The bytes of one event are sent on consecutive cycles. dataOut is 0x00 whenever dataValid is 0. At least one idle cycle separates two events.
- R11: Format, channel mask and chip identifier are sampled at the capture edge. Changing them later does not affect an event already taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSparse | input | 1 | 0 selects full format, 1 selects sparse format |
| cfgChanMask | input | 32 | Channel suppression, 1 disables a channel |
| cfgChipId | input | 4 | Chip identifier placed in the header |
| evValid | input | 1 | An event is available at the inputs |
| evReady | output | 1 | Event is taken at this edge |
| evCount | input | 2 | Number of crossings in the event (1 to 3) |
| evHit | input | 96 | Hit flags, bit c*32+ch |
| evTime | input | 576 | Fine times, bits (c*32+ch)*6 +: 6 |
| evBunch | input | 12 | Bunch counter |
| evId | input | 8 | Event counter |
| evOverflow | input | 1 | Upstream overflow flag copied to status |
| dataOut | output | 8 | Output byte |
| dataValid | output | 1 | dataOut holds a byte of an event |

## Verification
The bench uses the default parameters: 32 channels, 3 crossings and a 36-byte budget. With these values a full-format event fills the budget exactly. A sparse event with one crossing and 28 hits lands exactly on the budget, and 29 hits crosses it by one byte. Three crossings with many hits give deep truncation, so the edge of truncation and the deep case are both tested. The bench also sends events back to back while other events are still in flight, and it changes the configuration after capture.

// File: rtl/rd_fmt_pkg.sv
package rd_fmt_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_HDR,
    K_CHAN,
    K_MASK,
    K_TIME
  } emitKind_t;

  typedef struct packed {
    logic      capture;
    emitKind_t kind;
    logic [7:0] idx;
    logic [1:0] xing;
  } ctrlStrobes_t;
endpackage

// File: rtl/rd_fmt_ctrl.sv
module rd_fmt_ctrl
  import rd_fmt_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int BUDGET = 36
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         evValid,
  input  logic         modeSparse,
  input  logic [1:0]   nxCap,
  input  logic         pendEmpty,
  input  logic         pendLast,
  output ctrlStrobes_t strb,
  output logic         evReady
);
  localparam int MB = NCH / 8;
  localparam int CW = $clog2(BUDGET + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_CHAN, S_MASK, S_TIME} state_t;

  state_t        state, nState;
  logic [7:0]    idx, nIdx;
  logic [1:0]    xing, nXing;
  logic [CW-1:0] byteCnt, nByteCnt;
  logic          lastByte, moreX;
  logic [2:0]    xNext;

  always_comb begin
    strb.capture = (state == S_IDLE) && evValid;
    strb.idx     = idx;
    strb.xing    = xing;
    unique case (state)
      S_HDR:   strb.kind = K_HDR;
      S_CHAN:  strb.kind = K_CHAN;
      S_MASK:  strb.kind = K_MASK;
      S_TIME:  strb.kind = K_TIME;
      default: strb.kind = K_NONE;
    endcase
  end
  assign evReady = strb.capture;

  assign lastByte = (byteCnt == CW'(BUDGET - 1));
  assign xNext    = {1'b0, xing} + 3'd1;
  assign moreX    = xNext < {1'b0, nxCap};

  always_comb begin
    nState   = state;
    nIdx     = idx;
    nXing    = xing;
    nByteCnt = byteCnt;
    if (state == S_IDLE) begin
      if (strb.capture) begin
        nState   = S_HDR;
        nIdx     = '0;
        nXing    = '0;
        nByteCnt = '0;
      end
    end else begin
      nByteCnt = byteCnt + 1'b1;
      unique case (state)
        S_HDR: begin
          if (idx == 8'd3) begin
            nIdx   = '0;
            nState = modeSparse ? S_MASK : S_CHAN;
          end else nIdx = idx + 8'd1;
        end
        S_CHAN: begin
          if (idx == 8'(NCH - 1)) nState = S_IDLE;
          else nIdx = idx + 8'd1;
        end
        S_MASK: begin
          if (idx == 8'(MB - 1)) begin
            nIdx = '0;
            if (!pendEmpty) nState = S_TIME;
            else if (moreX) begin
              nState = S_MASK;
              nXing  = xNext[1:0];
            end else nState = S_IDLE;
          end else nIdx = idx + 8'd1;
        end
        S_TIME: begin
          if (pendLast) begin
            nIdx = '0;
            if (moreX) begin
              nState = S_MASK;
              nXing  = xNext[1:0];
            end else nState = S_IDLE;
          end
        end
        default: nState = S_IDLE;
      endcase
      if (lastByte) nState = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      xing    <= '0;
      byteCnt <= '0;
    end else begin
      state   <= nState;
      idx     <= nIdx;
      xing    <= nXing;
      byteCnt <= nByteCnt;
    end
  end
endmodule

// File: rtl/rd_fmt_dp.sv
module rd_fmt_dp
  import rd_fmt_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int NX     = 3,
  parameter int TW     = 6,
  parameter int BUDGET = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic                 cfgSparse,
  input  logic [NCH-1:0]       cfgChanMask,
  input  logic [3:0]           cfgChipId,
  input  logic [1:0]           evCount,
  input  logic [NX*NCH-1:0]    evHit,
  input  logic [NX*NCH*TW-1:0] evTime,
  input  logic [11:0]          evBunch,
  input  logic [7:0]           evId,
  input  logic                 evOverflow,
  output logic                 modeSparse,
  output logic [1:0]           nxCap,
  output logic                 pendEmpty,
  output logic                 pendLast,
  output logic [7:0]           dataOut,
  output logic                 dataValid
);
  localparam int MB  = NCH / 8;
  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0] hitM [NX];
  logic [NCH-1:0] pend [NX];
  logic [TW-1:0]  tim  [NX][NCH];
  logic [NCH-1:0] hitNew [NX];
  logic [3:0]     chipCap;
  logic [11:0]    bunchCap;
  logic [7:0]     idCap;
  logic           ovfCap, truncCap;
  logic [15:0]    need;
  logic [NCH-1:0] cur;
  logic [CHW-1:0] lowCh, chIdx;
  logic [7:0]     byteVal, maskByte, chanByte;
  int             xs;

  always_comb begin
    need = cfgSparse ? 16'(4 + MB * int'(evCount)) : 16'(4 + NCH);
    for (int c = 0; c < NX; c++) begin
      hitNew[c] = (c < int'(evCount)) ? (evHit[c*NCH +: NCH] & ~cfgChanMask) : '0;
      for (int ch = 0; ch < NCH; ch++)
        if (cfgSparse) need = need + 16'(hitNew[c][ch]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NX; c++) begin
        hitM[c] <= '0;
        pend[c] <= '0;
        for (int ch = 0; ch < NCH; ch++) tim[c][ch] <= '0;
      end
      chipCap <= '0; bunchCap <= '0; idCap <= '0;
      ovfCap <= 1'b0; truncCap <= 1'b0; modeSparse <= 1'b0; nxCap <= '0;
    end else if (strb.capture) begin
      for (int c = 0; c < NX; c++) begin
        hitM[c] <= hitNew[c];
        pend[c] <= hitNew[c];
        for (int ch = 0; ch < NCH; ch++) tim[c][ch] <= evTime[(c*NCH+ch)*TW +: TW];
      end
      chipCap    <= cfgChipId;
      bunchCap   <= evBunch;
      idCap      <= evId;
      ovfCap     <= evOverflow;
      truncCap   <= need > 16'(BUDGET);
      modeSparse <= cfgSparse;
      nxCap      <= evCount;
    end else if (strb.kind == K_TIME) begin
      pend[xs] <= cur & (cur - 1'b1);
    end
  end

  assign xs        = (int'(strb.xing) < NX) ? int'(strb.xing) : 0;
  assign cur       = pend[xs];
  assign pendEmpty = (cur == '0);
  assign pendLast  = ((cur & (cur - 1'b1)) == '0);
  assign chIdx     = strb.idx[CHW-1:0];

  always_comb begin
    lowCh = '0;
    for (int ch = NCH - 1; ch >= 0; ch--)
      if (cur[ch]) lowCh = CHW'(ch);
  end

  always_comb begin
    chanByte = 8'h3F;
    for (int c = NX - 1; c >= 0; c--)
      if (hitM[c][chIdx]) chanByte = {2'b10, tim[c][chIdx]};
    maskByte = hitM[xs][(MB - 1 - int'(strb.idx[CHW-1:0])) * 8 +: 8];
  end

  always_comb begin
    unique case (strb.kind)
      K_HDR: begin
        unique case (strb.idx[1:0])
          2'd0:    byteVal = {chipCap, bunchCap[11:8]};
          2'd1:    byteVal = bunchCap[7:0];
          2'd2:    byteVal = idCap;
          default: byteVal = {truncCap, ovfCap, modeSparse, 5'b00000};
        endcase
      end
      K_CHAN:  byteVal = chanByte;
      K_MASK:  byteVal = maskByte;
      K_TIME:  byteVal = {2'b10, tim[xs][lowCh]};
      default: byteVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= 8'h00;
      dataValid <= 1'b0;
    end else begin
      dataValid <= (strb.kind != K_NONE);
      dataOut   <= (strb.kind != K_NONE) ? byteVal : 8'h00;
    end
  end
endmodule

// File: rtl/rd_formatter.sv
module rd_formatter
  import rd_fmt_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int NX     = 3,
  parameter int TW     = 6,
  parameter int BUDGET = 36
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgSparse,
  input  logic [NCH-1:0]       cfgChanMask,
  input  logic [3:0]           cfgChipId,
  input  logic                 evValid,
  output logic                 evReady,
  input  logic [1:0]           evCount,
  input  logic [NX*NCH-1:0]    evHit,
  input  logic [NX*NCH*TW-1:0] evTime,
  input  logic [11:0]          evBunch,
  input  logic [7:0]           evId,
  input  logic                 evOverflow,
  output logic [7:0]           dataOut,
  output logic                 dataValid
);
  ctrlStrobes_t strb;
  logic         modeSparse, pendEmpty, pendLast;
  logic [1:0]   nxCap;

  rd_fmt_ctrl #(.NCH(NCH), .BUDGET(BUDGET)) ctrl_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .modeSparse(modeSparse),
    .nxCap(nxCap), .pendEmpty(pendEmpty), .pendLast(pendLast),
    .strb(strb), .evReady(evReady)
  );

  rd_fmt_dp #(.NCH(NCH), .NX(NX), .TW(TW), .BUDGET(BUDGET)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSparse(cfgSparse),
    .cfgChanMask(cfgChanMask), .cfgChipId(cfgChipId), .evCount(evCount),
    .evHit(evHit), .evTime(evTime), .evBunch(evBunch), .evId(evId),
    .evOverflow(evOverflow), .modeSparse(modeSparse), .nxCap(nxCap),
    .pendEmpty(pendEmpty), .pendLast(pendLast), .dataOut(dataOut),
    .dataValid(dataValid)
  );
endmodule

// File: rtl/rd_formatter_chk.sv
module rd_formatter_chk #(
  parameter int BUDGET = 36
) (
  input logic       clk,
  input logic       rstN,
  input logic       evValid,
  input logic       evReady,
  input logic       dataValid,
  input logic [7:0] dataOut
);
  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else runLen <= dataValid ? runLen + 1 : 0;
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> dataOut == 8'h00);

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    evReady |-> evValid);

  // R2
  hdr_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    evReady |=> !dataValid ##1 dataValid);

  // R9
  budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> runLen < BUDGET);
endmodule

bind rd_formatter rd_formatter_chk #(.BUDGET(BUDGET)) chk_i (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evReady(evReady),
  .dataValid(dataValid), .dataOut(dataOut)
);

// File: tb/rd_formatter_tb_top.sv
module rd_formatter_tb_top;
  localparam int NCH = 32;
  localparam int NX = 3;
  localparam int TW = 6;
  localparam int BUDGET = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSparse = 1'b0;
  logic [NCH-1:0] cfgChanMask = '0;
  logic [3:0] cfgChipId = '0;
  logic evValid = 1'b0;
  logic evReady;
  logic [1:0] evCount = 2'd1;
  logic [NX*NCH-1:0] evHit = '0;
  logic [NX*NCH*TW-1:0] evTime = '0;
  logic [11:0] evBunch = '0;
  logic [7:0] evId = '0;
  logic evOverflow = 1'b0;
  logic [7:0] dataOut;
  logic dataValid;

  always #4 clk = ~clk;

  rd_formatter #(.NCH(NCH), .NX(NX), .TW(TW), .BUDGET(BUDGET)) dut_i (
    .clk(clk), .rstN(rstN), .cfgSparse(cfgSparse), .cfgChanMask(cfgChanMask),
    .cfgChipId(cfgChipId), .evValid(evValid), .evReady(evReady),
    .evCount(evCount), .evHit(evHit), .evTime(evTime), .evBunch(evBunch),
    .evId(evId), .evOverflow(evOverflow), .dataOut(dataOut), .dataValid(dataValid)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  logic [7:0] expQ[$];
  string expTag[$];
  int expLen[$];
  int capQ[$];
  int curRemain = 0;
  int lastEndCyc = -10;
  logic monOn = 1'b0;
  logic [NCH-1:0] tHit[NX];
  logic [TW-1:0] tTime[NX][NCH];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      finishRun();
    end
  end

  // reference comparison on every clock (sampled at the falling edge)
  always @(negedge clk) begin
    if (rstN && monOn) begin
      if (dataValid) begin
        if (curRemain == 0) begin
          if (expLen.size() == 0) chk(1'b0, "R10 unexpected byte", dataOut, 0);
          else begin
            curRemain = expLen.pop_front();
            chk(capQ.size() > 0 && cyc == capQ[0] + 1, "R2 header latency", cyc,
                capQ.size() > 0 ? capQ[0] + 1 : -1);
            if (capQ.size() > 0) void'(capQ.pop_front());
            chk(lastEndCyc != cyc - 1, "R10 idle between events", lastEndCyc, cyc - 2);
          end
        end
        if (curRemain > 0) begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = expTag.pop_front();
          chk(dataOut == e, t, dataOut, e);
          curRemain--;
          if (curRemain == 0) lastEndCyc = cyc;
        end
      end else begin
        if (dataOut != 8'h00) chk(1'b0, "R10 idle byte", dataOut, 0);
        if (curRemain > 0) chk(1'b0, "R10 gap inside event", 0, 1);
      end
    end
  end

  task automatic sendEvent(input logic sparse, input logic [NCH-1:0] msk,
                           input logic [3:0] chip, input int nx,
                           input logic [11:0] bx, input logic [7:0] eid,
                           input logic ovf, input string tag);
    logic [7:0] body[$];
    int total;
    logic trunc;
    for (int c = 0; c < nx; c++) begin end
    if (!sparse) begin
      for (int ch = 0; ch < NCH; ch++) begin
        bit found = 0;
        for (int c = 0; c < nx; c++)
          if (!found && tHit[c][ch] && !msk[ch]) begin
            body.push_back({2'b10, tTime[c][ch]});
            found = 1;
          end
        if (!found) body.push_back(8'h3F);
      end
    end else begin
      for (int c = 0; c < nx; c++) begin
        logic [NCH-1:0] m;
        m = tHit[c] & ~msk;
        for (int b = NCH / 8 - 1; b >= 0; b--) body.push_back(m[b*8 +: 8]);
        for (int ch = 0; ch < NCH; ch++)
          if (m[ch]) body.push_back({2'b10, tTime[c][ch]});
      end
    end
    total = 4 + body.size();
    trunc = total > BUDGET;
    expQ.push_back({chip, bx[11:8]}); expTag.push_back("R3 header byte0");
    expQ.push_back(bx[7:0]);          expTag.push_back("R3 header byte1");
    expQ.push_back(eid);              expTag.push_back("R3 header byte2");
    expQ.push_back({trunc, ovf, sparse, 5'b00000}); expTag.push_back("R3/R9 status");
    for (int i = 0; i < body.size() && i + 4 < BUDGET; i++) begin
      expQ.push_back(body[i]);
      expTag.push_back(tag);
    end
    expLen.push_back(trunc ? BUDGET : total);
    @(negedge clk);
    cfgSparse = sparse;
    cfgChanMask = msk;
    cfgChipId = chip;
    evCount = 2'(nx);
    evBunch = bx;
    evId = eid;
    evOverflow = ovf;
    for (int c = 0; c < NX; c++)
      for (int ch = 0; ch < NCH; ch++) begin
        evHit[c*NCH+ch] = tHit[c][ch];
        evTime[(c*NCH+ch)*TW +: TW] = tTime[c][ch];
      end
    evValid = 1'b1;
    #1;
    while (!evReady) @(negedge clk);
    @(posedge clk);
    #1;
    capQ.push_back(cyc);
    evValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0 || curRemain != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic setPattern(input int seed);
    for (int c = 0; c < NX; c++) begin
      tHit[c] = '0;
      for (int ch = 0; ch < NCH; ch++) tTime[c][ch] = TW'(seed + c * 17 + ch * 5);
    end
  endtask

  initial begin
    setPattern(0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dataValid == 1'b0, "R1 valid in reset", dataValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(dataValid == 1'b0, "R1 valid after reset", dataValid, 0);
    chk(dataOut == 8'h00, "R1 idle byte after reset", dataOut, 0);
    chk(evReady == 1'b0, "R1 ready without event", evReady, 0);
    monOn = 1'b1;

    // R4: full format, no hits
    setPattern(1);
    sendEvent(1'b0, '0, 4'hA, 1, 12'hABC, 8'h01, 1'b0, "R4 empty channel");
    drain();

    // R4: full format, even channels hit, overflow flag
    setPattern(2);
    tHit[0] = 32'h5555_5555;
    sendEvent(1'b0, '0, 4'h3, 1, 12'h123, 8'h02, 1'b1, "R4 channel byte");
    drain();

    // R5 and R8: earliest crossing wins, crossing 2 ignored with count 2
    setPattern(3);
    tHit[0] = 32'h0000_00F0;
    tHit[1] = 32'h0000_0FF0;
    tHit[2] = 32'hF000_F00F;
    sendEvent(1'b0, '0, 4'h5, 2, 12'h800, 8'h03, 1'b0, "R5/R8 first hit");
    drain();

    // R5: three crossings
    sendEvent(1'b0, '0, 4'h5, 3, 12'h801, 8'h04, 1'b0, "R5 three crossings");
    drain();

    // R6: masked channels in full format
    setPattern(4);
    tHit[0] = 32'hFFFF_FFFF;
    sendEvent(1'b0, 32'h0F0F_00FF, 4'h1, 1, 12'h010, 8'h05, 1'b0, "R6 full masked");
    drain();

    // R7: sparse, one crossing, few hits
    setPattern(5);
    tHit[0] = 32'h8001_0402;
    sendEvent(1'b1, '0, 4'h7, 1, 12'hFFF, 8'h06, 1'b0, "R7 sparse single");
    drain();

    // R7 and R6: sparse three crossings, empty middle crossing, mask
    setPattern(6);
    tHit[0] = 32'h0000_0013;
    tHit[1] = 32'h0000_0100;
    tHit[2] = 32'hC000_0001;
    sendEvent(1'b1, 32'h0000_0100, 4'h9, 3, 12'h444, 8'h07, 1'b0, "R7/R6 sparse multi");
    drain();

    // R8: sparse, crossing beyond count has hits
    setPattern(7);
    tHit[0] = 32'h0000_0001;
    tHit[1] = 32'h0000_0002;
    tHit[2] = 32'hFFFF_FFFF;
    sendEvent(1'b1, '0, 4'h2, 2, 12'h222, 8'h08, 1'b0, "R8 sparse ignored crossing");
    drain();

    // R9: exactly at budget, not truncated
    setPattern(8);
    tHit[0] = 32'h0FFF_FFFF;
    sendEvent(1'b1, '0, 4'hC, 1, 12'h0C0, 8'h09, 1'b0, "R9 exact budget");
    drain();

    // R9: one byte over budget
    tHit[0] = 32'h1FFF_FFFF;
    sendEvent(1'b1, '0, 4'hC, 1, 12'h0C1, 8'h0A, 1'b0, "R9 one over");
    drain();

    // R9: deep truncation over three crossings
    setPattern(9);
    tHit[0] = 32'hFFFF_FFFF;
    tHit[1] = 32'hFFFF_FFFF;
    tHit[2] = 32'hFFFF_FFFF;
    sendEvent(1'b1, '0, 4'hD, 3, 12'h0C2, 8'h0B, 1'b1, "R9 deep truncation");
    drain();

    // R11: configuration changed right after capture
    setPattern(10);
    tHit[0] = 32'h0000_F00F;
    sendEvent(1'b1, 32'h0000_0001, 4'h6, 1, 12'h321, 8'h0C, 1'b0, "R11 sampled config");
    cfgSparse = 1'b0;
    cfgChanMask = 32'hFFFF_FFFF;
    cfgChipId = 4'hF;
    evHit = '1;
    drain();

    // R10 and R2: back-to-back events
    setPattern(11);
    tHit[0] = 32'h0000_0003;
    sendEvent(1'b1, '0, 4'h4, 1, 12'h100, 8'h0D, 1'b0, "R10 back to back a");
    tHit[0] = 32'h8000_0000;
    sendEvent(1'b0, '0, 4'h4, 1, 12'h101, 8'h0E, 1'b0, "R10 back to back b");
    tHit[0] = 32'h0000_0000;
    sendEvent(1'b1, '0, 4'h4, 1, 12'h102, 8'h0F, 1'b0, "R10 back to back c");
    drain();

    finishRun();
  end
endmodule